// File: doc/BRIEF.md
# Banked Debug Comparator Register Window

This block holds the register state for the four comparator channels of an on-chip debug unit. Software reaches all four channels through one shared eight-byte window in the peripheral map. A two-bit bank selector, kept in a register outside this block, picks which channel that window currently shows. Channels 0 and 2 are full comparators: each has a control byte, three address bytes, two data bytes and two data-mask bytes. Channels 1 and 3 are reduced: they have only the control byte and the three address bytes. On a reduced channel the four data and mask locations read as zero, and writes to them are dropped.

The block also keeps a sticky match-flag byte, with one flag per channel. The comparison logic elsewhere pulses a channel's match input, and that sets the channel's flag. The flag stays set until the unit is armed again, and only the arm strobe clears flags. The flag byte sits at the address just before the window. It reads back only while the bank selector is 3; at any other selector value that address reads zero. Every stored comparator byte is driven out continuously, so the comparison logic can use it.

The read/write port is synchronous. A write takes effect on the clock edge where the write enable is high. A read registers its result, so read data is valid one cycle after the read enable.

Top module: `dbg_cmp_window`

## Requirements
- R1: After reset, every comparator byte, every match flag and the read data output are zero.
- R2: A write with `wr_en` high updates only the addressed byte of the channel that `bank_sel` selects, on that clock edge. All other channels and bytes keep their values.
- R3: Address 8 + k maps to window byte k of the selected channel. The byte order for k = 0..7 is: control, address bits 23:16, address bits 15:8, address bits 7:0, data bits 15:8, data bits 7:0, mask bits 15:8, mask bits 7:0.
- R4: When `bank_sel` selects channel 1 or 3, window bytes 4 to 7 read as zero, and writes to them change no state.
- R5: Address 7 returns the match flags only when `bank_sel` is 3, with channel i in bit i and bits 7:4 zero. At any other `bank_sel` value, address 7 reads zero.
- R6: A high bit of `match_pulse` sets the matching flag at the next edge. A flag stays set through any number of further matches. It does not keep other channels' flags from being set.
- R7: A write to address 7, at any bank selection, leaves all match flags unchanged.
- R8: An `arm_wr` strobe clears all four flags at the next edge. A match pulse in the same cycle as `arm_wr` does not survive: the flag ends up cleared.
- R9: `cmp_ctrl_o`, `cmp_addr_o`, `cmp_data_o` and `cmp_mask_o` carry channel i's stored bytes in slices 8i, 24i, 16i and 16i respectively. The data and mask slices of channels 1 and 3 are always zero.
- R10: `rd_data` shows the byte addressed in the cycle where `rd_en` was high, one edge later. It holds while `rd_en` is low. Addresses 0 to 6 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Selects which channel the window exposes |
| addr | input | 4 | Register byte address (7 = flags, 8..15 = window) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; result registered |
| rd_data | output | 8 | Registered read byte |
| match_pulse | input | 4 | Per-channel match event, bit i = channel i |
| arm_wr | input | 1 | Arm event; clears all match flags |
| match_flags | output | 4 | Current sticky flags |
| cmp_ctrl_o | output | 32 | Control byte of each channel |
| cmp_addr_o | output | 96 | 24-bit compare address of each channel |
| cmp_data_o | output | 64 | 16-bit compare data of each channel |
| cmp_mask_o | output | 64 | 16-bit data mask of each channel |

## Verification
The assertions check the following on every cycle:
- the flags never fall without an arm and never rise without a match;
- an arm always empties the flags;
- at most one channel takes a given write;
- a channel that receives no write keeps its bytes;
- reduced-channel data locations and the hidden flag address always read zero;
- read data holds while reads are idle.

Only the bench's scenarios can show that the byte map and ordering are correct, and that a write lands in the right channel and byte rather than in some other one. That work uses long random mixes of writes, reads, matches and arms against a reference model. The bench also covers the same-cycle arm-and-match case and writes aimed at the flag address.

// File: rtl/dbgwin_pkg.sv
package dbgwin_pkg;
  localparam int NUM_CH     = 4;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int BYTE_W     = 8;
  localparam int WIN_BYTES  = 8;
  localparam int OFF_W      = $clog2(WIN_BYTES);
  localparam int ADDR_W     = 4;
  localparam int WIN_BASE   = 8;
  localparam int FLAG_ADDR  = WIN_BASE - 1;
  localparam int FLAG_SEL   = NUM_CH - 1;
  localparam int CADDR_BYTES = 3;
  localparam int CDATA_BYTES = 2;
  localparam int CADDR_W    = CADDR_BYTES * BYTE_W;
  localparam int CDATA_W    = CDATA_BYTES * BYTE_W;

  typedef enum logic [OFF_W-1:0] {
    OFF_CTRL  = 3'd0,
    OFF_ADR_H = 3'd1,
    OFF_ADR_M = 3'd2,
    OFF_ADR_L = 3'd3,
    OFF_DAT_H = 3'd4,
    OFF_DAT_L = 3'd5,
    OFF_MSK_H = 3'd6,
    OFF_MSK_L = 3'd7
  } win_off_e;

  // Window offsets from the first data byte upward exist only on full channels.
  function automatic logic off_is_data(input logic [OFF_W-1:0] off);
    return off >= OFF_DAT_H;
  endfunction

  // Even channels carry data and mask bytes; odd channels are reduced.
  function automatic bit ch_is_full(input int ch);
    return (ch % 2) == 0;
  endfunction

  function automatic logic [BYTE_W-1:0] flag_byte(input logic [NUM_CH-1:0] f);
    return {{(BYTE_W-NUM_CH){1'b0}}, f};
  endfunction
endpackage

// File: rtl/dbgwin_decode.sv
module dbgwin_decode
  import dbgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CH_W-1:0]   bank_sel,
  input  logic              wr_en,
  output logic              flag_visible,
  output logic              win_hit,
  output logic [OFF_W-1:0]  win_off,
  output logic [NUM_CH-1:0] bank_we
);
  logic flag_addr_hit;

  assign flag_addr_hit = (int'(addr) == FLAG_ADDR);
  assign flag_visible  = flag_addr_hit && (int'(bank_sel) == FLAG_SEL);
  assign win_hit       = (int'(addr) >= WIN_BASE) && (int'(addr) < WIN_BASE + WIN_BYTES);
  assign win_off       = OFF_W'(int'(addr) - WIN_BASE);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_we
    assign bank_we[g] = wr_en && win_hit && (int'(bank_sel) == g);
  end

  // R2: a single write reaches at most one channel.
  p_we_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  // R10: writes outside the window never enable a bank.
  p_no_we_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) < WIN_BASE) |-> (bank_we == '0));
endmodule

// File: rtl/cmp_bank_regs.sv
module cmp_bank_regs
  import dbgwin_pkg::*;
#(
  parameter bit FULL = 1'b1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [CADDR_W-1:0] addr_o,
  output logic [CDATA_W-1:0] data_o,
  output logic [CDATA_W-1:0] mask_o
);
  logic [BYTE_W-1:0]  ctrl_q;
  logic [CADDR_W-1:0] caddr_q;
  logic               wr_accept;
  logic [BYTE_W-1:0]  base_rd;
  logic [BYTE_W-1:0]  ext_rd;

  assign wr_accept = wr_en && (FULL || !off_is_data(wr_off));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      caddr_q <= '0;
    end else if (wr_accept) begin
      case (win_off_e'(wr_off))
        OFF_CTRL:  ctrl_q <= wr_data;
        OFF_ADR_H: caddr_q[2*BYTE_W +: BYTE_W] <= wr_data;
        OFF_ADR_M: caddr_q[1*BYTE_W +: BYTE_W] <= wr_data;
        OFF_ADR_L: caddr_q[0 +: BYTE_W] <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (win_off_e'(rd_off))
      OFF_CTRL:  base_rd = ctrl_q;
      OFF_ADR_H: base_rd = caddr_q[2*BYTE_W +: BYTE_W];
      OFF_ADR_M: base_rd = caddr_q[1*BYTE_W +: BYTE_W];
      OFF_ADR_L: base_rd = caddr_q[0 +: BYTE_W];
      default:   base_rd = '0;
    endcase
  end

  if (FULL) begin : g_full
    logic [CDATA_W-1:0] cdata_q;
    logic [CDATA_W-1:0] cmask_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cdata_q <= '0;
        cmask_q <= '0;
      end else if (wr_accept) begin
        case (win_off_e'(wr_off))
          OFF_DAT_H: cdata_q[BYTE_W +: BYTE_W] <= wr_data;
          OFF_DAT_L: cdata_q[0 +: BYTE_W]      <= wr_data;
          OFF_MSK_H: cmask_q[BYTE_W +: BYTE_W] <= wr_data;
          OFF_MSK_L: cmask_q[0 +: BYTE_W]      <= wr_data;
          default: ;
        endcase
      end
    end

    always_comb begin
      case (win_off_e'(rd_off))
        OFF_DAT_H: ext_rd = cdata_q[BYTE_W +: BYTE_W];
        OFF_DAT_L: ext_rd = cdata_q[0 +: BYTE_W];
        OFF_MSK_H: ext_rd = cmask_q[BYTE_W +: BYTE_W];
        OFF_MSK_L: ext_rd = cmask_q[0 +: BYTE_W];
        default:   ext_rd = '0;
      endcase
    end

    assign data_o = cdata_q;
    assign mask_o = cmask_q;

    // R2: data and mask bytes hold while the channel takes no write.
    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(cdata_q) && $stable(cmask_q)));
  end else begin : g_reduced
    assign ext_rd = '0;
    assign data_o = '0;
    assign mask_o = '0;
  end

  assign rd_byte = off_is_data(rd_off) ? ext_rd : base_rd;
  assign ctrl_o  = ctrl_q;
  assign addr_o  = caddr_q;

  // R2: control and address bytes hold while the channel takes no write.
  p_base_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl_q) && $stable(caddr_q)));

  // R4: data-region writes leave the control and address bytes alone.
  p_data_wr_spares_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off_is_data(wr_off)) |=> ($stable(ctrl_q) && $stable(caddr_q)));
endmodule

// File: rtl/match_flag_reg.sv
module match_flag_reg
  import dbgwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [NUM_CH-1:0] match,
  output logic [NUM_CH-1:0] flags_o
);
  logic [NUM_CH-1:0] flags_q;
  logic [NUM_CH-1:0] set_now;

  // Newly raised flags this cycle; arming suppresses every set.
  assign set_now = match & ~flags_q & {NUM_CH{~arm}};

  always_ff @(posedge clk) begin
    if (!rst_n)   flags_q <= '0;
    else if (arm) flags_q <= '0;
    else          flags_q <= flags_q | set_now;
  end

  assign flags_o = flags_q;

  // R6: without an arm, no flag ever falls.
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R6: a match without an arm leaves its flag set.
  p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && match != '0) |=> ((flags_q & $past(match)) == $past(match)));

  // R7: no flag rises except on a match.
  p_rise_needs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(match)) == '0));

  // R8: arming empties the register even against a simultaneous match.
  p_arm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (flags_q == '0));
endmodule

// File: rtl/dbg_cmp_window.sv
module dbg_cmp_window
  import dbgwin_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CH_W-1:0]             bank_sel,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_en,
  input  logic [BYTE_W-1:0]           wr_data,
  input  logic                        rd_en,
  output logic [BYTE_W-1:0]           rd_data,
  input  logic [NUM_CH-1:0]           match_pulse,
  input  logic                        arm_wr,
  output logic [NUM_CH-1:0]           match_flags,
  output logic [NUM_CH*BYTE_W-1:0]    cmp_ctrl_o,
  output logic [NUM_CH*CADDR_W-1:0]   cmp_addr_o,
  output logic [NUM_CH*CDATA_W-1:0]   cmp_data_o,
  output logic [NUM_CH*CDATA_W-1:0]   cmp_mask_o
);
  logic                           flag_visible;
  logic                           win_hit;
  logic [OFF_W-1:0]               win_off;
  logic [NUM_CH-1:0]              bank_we;
  logic [NUM_CH-1:0][BYTE_W-1:0]  bank_rd;
  logic [NUM_CH-1:0]              flags;
  logic [BYTE_W-1:0]              rd_next;
  logic [BYTE_W-1:0]              rd_q;
  logic                           sel_reduced;

  dbgwin_decode u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .bank_sel     (bank_sel),
    .wr_en        (wr_en),
    .flag_visible (flag_visible),
    .win_hit      (win_hit),
    .win_off      (win_off),
    .bank_we      (bank_we)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
    cmp_bank_regs #(.FULL(ch_is_full(g))) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we[g]),
      .wr_off  (win_off),
      .wr_data (wr_data),
      .rd_off  (win_off),
      .rd_byte (bank_rd[g]),
      .ctrl_o  (cmp_ctrl_o[g*BYTE_W +: BYTE_W]),
      .addr_o  (cmp_addr_o[g*CADDR_W +: CADDR_W]),
      .data_o  (cmp_data_o[g*CDATA_W +: CDATA_W]),
      .mask_o  (cmp_mask_o[g*CDATA_W +: CDATA_W])
    );
  end

  match_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm_wr),
    .match   (match_pulse),
    .flags_o (flags)
  );

  always_comb begin
    if (flag_visible)  rd_next = flag_byte(flags);
    else if (win_hit)  rd_next = bank_rd[bank_sel];
    else               rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_en)  rd_q <= rd_next;
  end

  assign rd_data     = rd_q;
  assign match_flags = flags;
  assign sel_reduced = bank_sel[0];

  // R4: data and mask locations of a reduced channel read zero.
  p_reduced_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_reduced && int'(addr) >= WIN_BASE + 4) |=> (rd_data == '0));

  // R5: the flag address is blank unless the last bank is selected.
  p_flag_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) == FLAG_ADDR && int'(bank_sel) != FLAG_SEL) |=> (rd_data == '0));

  // R5: reserved upper flag bits read zero.
  p_flag_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) == FLAG_ADDR) |=> (rd_data[BYTE_W-1:NUM_CH] == '0));

  // R10: read data holds between reads.
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R9: reduced channels never drive data or mask values.
  p_reduced_outputs_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_data_o[1*CDATA_W +: CDATA_W] == '0) && (cmp_data_o[3*CDATA_W +: CDATA_W] == '0) &&
    (cmp_mask_o[1*CDATA_W +: CDATA_W] == '0) && (cmp_mask_o[3*CDATA_W +: CDATA_W] == '0));
endmodule

// File: tb/dbg_cmp_window_tb.sv
module dbg_cmp_window_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bank_sel;
  logic [3:0]  addr;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        rd_en;
  logic [7:0]  rd_data;
  logic [3:0]  match_pulse;
  logic        arm_wr;
  logic [3:0]  match_flags;
  logic [31:0] cmp_ctrl_o;
  logic [95:0] cmp_addr_o;
  logic [63:0] cmp_data_o;
  logic [63:0] cmp_mask_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] mem [4][8];
  logic [3:0] mflags;

  always #2.5 clk = ~clk;

  dbg_cmp_window u_dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .match_pulse(match_pulse), .arm_wr(arm_wr), .match_flags(match_flags),
    .cmp_ctrl_o(cmp_ctrl_o), .cmp_addr_o(cmp_addr_o),
    .cmp_data_o(cmp_data_o), .cmp_mask_o(cmp_mask_o)
  );

  function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [1:0] bs);
    if (a == 4'd7) return (bs == 2'd3) ? {4'b0, mflags} : 8'h00;
    if (a >= 4'd8) begin
      if (bs[0] && a >= 4'd12) return 8'h00;
      return mem[bs][a - 4'd8];
    end
    return 8'h00;
  endfunction

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    for (int i = 0; i < 4; i++) begin
      check(cmp_ctrl_o[8*i +: 8], mem[i][0], req);
      check(cmp_addr_o[24*i +: 24], {mem[i][1], mem[i][2], mem[i][3]}, req);
      check(cmp_data_o[16*i +: 16], {mem[i][4], mem[i][5]}, req);
      check(cmp_mask_o[16*i +: 16], {mem[i][6], mem[i][7]}, req);
    end
  endtask

  // One clock: drive after a falling edge, check at the next falling edge.
  task automatic step(input logic we, input logic re, input logic [3:0] a,
                      input logic [7:0] d, input logic [1:0] bs,
                      input logic [3:0] m, input logic arm, input string req);
    logic [7:0] exp_rd;
    logic [7:0] prev_rd;
    prev_rd = rd_data;
    wr_en = we; rd_en = re; addr = a; wr_data = d; bank_sel = bs;
    match_pulse = m; arm_wr = arm;
    exp_rd = re ? exp_read(a, bs) : prev_rd;
    if (we && a >= 4'd8 && !(bs[0] && a >= 4'd12)) mem[bs][a - 4'd8] = d;
    if (arm) mflags = 4'h0;
    else     mflags = mflags | m;
    @(posedge clk);
    @(negedge clk);
    check(rd_data, exp_rd, req);
    check(match_flags, mflags, req);
    wr_en = 1'b0; rd_en = 1'b0; match_pulse = 4'h0; arm_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++) for (int o = 0; o < 8; o++) mem[b][o] = 8'h00;
    mflags = 4'h0;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wr_data = 0; bank_sel = 0;
    match_pulse = 0; arm_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(rd_data, 8'h00, "R1");
    check(match_flags, 4'h0, "R1");
    check_outputs("R1");

    // R3: fill every byte of every channel, then read back in order
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 8; o++)
        step(1, 0, 4'(8 + o), 8'(8'h11 * (o + 1) + 8'(b * 64)), 2'(b), 0, 0, "R2");
    check_outputs("R9");
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 8; o++)
        step(0, 1, 4'(8 + o), 8'h00, 2'(b), 0, 0, (b % 2 == 1 && o >= 4) ? "R4" : "R3");

    // R10: low addresses read zero and ignore writes; data holds while idle
    step(1, 1, 4'd2, 8'hA5, 2'd0, 0, 0, "R10");
    step(0, 0, 4'd8, 8'h00, 2'd0, 0, 0, "R10");
    check_outputs("R10");

    // R6: matches set flags, stay set, and don't block each other
    step(0, 0, 4'd0, 0, 2'd0, 4'b0001, 0, "R6");
    step(0, 0, 4'd0, 0, 2'd0, 4'b0001, 0, "R6");
    step(0, 0, 4'd0, 0, 2'd0, 4'b0100, 0, "R6");
    // R5: flags visible only at bank 3
    step(0, 1, 4'd7, 0, 2'd3, 0, 0, "R5");
    step(0, 1, 4'd7, 0, 2'd1, 0, 0, "R5");
    // R7: writes to the flag address change nothing
    step(1, 0, 4'd7, 8'hFF, 2'd3, 0, 0, "R7");
    step(1, 0, 4'd7, 8'h00, 2'd0, 0, 0, "R7");
    step(0, 1, 4'd7, 0, 2'd3, 0, 0, "R7");
    // R8: arm wins over a simultaneous match
    step(0, 0, 4'd0, 0, 2'd0, 4'b1010, 1, "R8");
    step(0, 1, 4'd7, 0, 2'd3, 0, 0, "R8");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a;
      logic       we;
      logic       re;
      logic       arm;
      a   = 4'($urandom_range(6, 15));
      we  = ($urandom_range(0, 2) == 0);
      re  = ($urandom_range(0, 1) == 0);
      arm = ($urandom_range(0, 19) == 0);
      step(we, re, a, 8'($urandom), 2'($urandom), ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0,
           arm, "R2");
      if (n % 100 == 0) check_outputs("R9");
    end
    check_outputs("R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule